// File: doc/BRIEF.md
# Partial Reconfiguration Host Sequencer

This block drives a target device's configuration port from outside the device. It runs two kinds of operation. A full-chip load checks the target's two configuration pins, streams a bitstream, and then checks the pins again. A partial reconfiguration freezes the target region, raises a request, and waits until the target reports that it can take data. It then streams a persona image and watches a 2-bit status code. When the code shows completion, it lifts the freeze.

Image bytes come from a 32-bit word buffer. The block gives the word address and expects the read data back in the same cycle. It packs the bytes onto a ready/valid stream that carries 1, 2 or 4 bytes per beat. A watchdog limits how long the block waits for completion after the last beat. Any failure parks the block in an error state with a cause code. In a partial reconfiguration the freeze stays on until software pulses `clear`.

Top module: `prhost_seq`

## Requirements
- R1: While reset is held and after it is released, `st_valid`, `freeze`, `pr_request`, `done` and `error` are 0 and `err_cause` is 0.
- R2: `start_full` in idle or done is accepted only when `conf_done` is 0 and `st_ready` is 1. Streaming then starts in the next cycle. Otherwise the block enters error with `err_cause` 1 (pin check) and sends no data.
- R3: After the last beat of a full-chip load, `done` rises only in the cycle after `conf_done` reads 1 and `st_ready` reads 0 together.
- R4: `start_pr` raises `freeze` alone for exactly one cycle. Then `freeze` and `pr_request` are high together.
- R5: After the request is raised, `st_valid` stays 0 until `st_ready` has been sampled 1. `st_valid` rises in the following cycle.
- R6: A beat is consumed only in a cycle with `st_valid` and `st_ready` both high. While `st_ready` is low, `buf_addr` and `st_data` hold.
- R7: Width code `mode_sel` selects the bytes per beat: 0 gives 1, 1 gives 2, 2 gives 4, and 3 gives 1. Beat k carries image bytes k*B upward, with byte i of the beat at bits 8i. Image byte n is in buffer word n/4 at bits 8*(n mod 4), and `buf_addr` holds the word index.
- R8: Bytes at or past `byte_len` and lanes above B bytes are driven 0. An image takes ceil(`byte_len`/B) beats, and a length of 0 sends no beat.
- R9: During streaming or waiting in a partial reconfiguration, a `pr_status` of 0 or 1 moves the block to error with `err_cause` 2 in the next cycle. `st_valid` and `pr_request` drop and `freeze` stays high.
- R10: In the wait phase of a partial reconfiguration, `pr_status` 3 makes `freeze` and `pr_request` fall and `done` rise in the next cycle. `pr_status` 2 keeps waiting.
- R11: The wait phase lasts at most `wd_limit`+1 cycles, counted from wait-cycle 0. If no completion is seen by wait-cycle `wd_limit`, the block enters error with `err_cause` 3.
- R12: In error only `clear` leaves, going to idle with `freeze` 0. Start pulses in error are ignored.
- R13: Width code, length and watchdog limit are captured at the accepted start. Later changes do not affect that operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_sel | input | 2 | Beat width code (R7) |
| byte_len | input | LEN_W | Image length in bytes |
| wd_limit | input | WD_W | Last wait-cycle index allowed for completion |
| start_full | input | 1 | Start a full-chip load |
| start_pr | input | 1 | Start a partial reconfiguration (wins over `start_full`) |
| clear | input | 1 | Leave error, or leave done |
| conf_done | input | 1 | Target configuration-done pin |
| st_ready | input | 1 | Target stream-ready pin |
| pr_status | input | 2 | Target reconfiguration status code |
| buf_addr | output | LEN_W-2 | Buffer word address |
| buf_rdata | input | 32 | Buffer word for `buf_addr`, same cycle |
| st_valid | output | 1 | Stream beat valid |
| st_data | output | 32 | Stream beat, low bytes used |
| freeze | output | 1 | Freeze of the target region |
| pr_request | output | 1 | Reconfiguration request |
| done | output | 1 | Last operation finished well |
| error | output | 1 | Block is in error |
| err_cause | output | 2 | 0 none, 1 pin check, 2 status, 3 timeout |

## Verification
The bench goes after stalls in the middle of a beat. A design that advanced on valid alone would skip bytes or change `st_data` under a low ready. It checks odd lengths in 16-bit and 32-bit modes, where a wrong pad would leak bytes past the end or send one beat too many or too few. It checks the exact watchdog cycle and a status error in mid-stream, where an off-by-one or a missed abort would show as early or late errors or as data sent after the failure. It also checks freeze and request ordering with ready held low, the pin checks on both sides of a full load, and width or length changes during a run.

// File: rtl/prhost_pkg.sv
// Shared types for the partial reconfiguration host sequencer.
// Assumes a 32-bit buffer word and at most 4 bytes per stream beat.
package prhost_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FREEZE,
        ST_REQ,
        ST_STREAM,
        ST_WAIT,
        ST_DONE,
        ST_ERROR
    } host_state_t;

    typedef enum logic [1:0] {
        CAUSE_NONE    = 2'd0,
        CAUSE_PINS    = 2'd1,
        CAUSE_STATUS  = 2'd2,
        CAUSE_TIMEOUT = 2'd3
    } err_cause_t;

    localparam int WORD_BYTES = 4;

    // Bytes per beat for a width code; the unused code falls back to one byte.
    function automatic logic [2:0] beat_bytes(input logic [1:0] code);
        case (code)
            2'd1:    beat_bytes = 3'd2;
            2'd2:    beat_bytes = 3'd4;
            default: beat_bytes = 3'd1;
        endcase
    endfunction

endpackage

// File: rtl/prhost_packer.sv
// Byte-lane packer: maps the current byte offset onto a buffer word address
// and selects the beat's bytes from that word, zeroing lanes past the beat
// width or past the image end.
// Assumes the offset is a multiple of the beat width, so a beat never spans
// two buffer words.
module prhost_packer #(
    parameter int LEN_W = 16
) (
    input  logic [2:0]       bytes,
    input  logic [LEN_W-1:0] pos,
    input  logic [LEN_W-1:0] len,
    input  logic [31:0]      word,
    output logic [LEN_W-3:0] addr,
    output logic [31:0]      data
);
    localparam int LANES = prhost_pkg::WORD_BYTES;

    assign addr = pos[LEN_W-1:2];

    // One lane per output byte: rotate the source lane, then mask.
    for (genvar j = 0; j < LANES; j++) begin : g_lane
        logic [1:0] src;
        logic       keep;
        assign src  = pos[1:0] + 2'(j);
        assign keep = (3'(j) < bytes) &&
                      (({1'b0, pos} + (LEN_W+1)'(j)) < {1'b0, len});
        assign data[8*j +: 8] = keep ? word[{src, 3'b000} +: 8] : 8'h00;
    end

endmodule

// File: rtl/prhost_wdog.sv
// Completion watchdog: counts cycles while the host waits and flags when
// the count reaches the limit.
// Assumes the limit stays fixed while run is high.
module prhost_wdog #(
    parameter int WD_W = 12
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic [WD_W-1:0] limit,
    output logic            expired
);
    logic [WD_W-1:0] cnt;

    // Counter: held at zero outside the wait phase, saturates at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
        end else if (cnt != limit) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign expired = run && (cnt == limit);

    a_r11_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt <= limit));

endmodule

// File: rtl/prhost_ctrl.sv
// Control state machine for the host: pin checks, freeze/request ordering,
// beat counting, status monitoring, completion and the error path.
// Assumes the buffer returns read data in the same cycle and that pr_status
// is meaningful from the request phase onward.
module prhost_ctrl
    import prhost_pkg::*;
#(
    parameter int LEN_W = 16,
    parameter int WD_W  = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       mode_sel,
    input  logic [LEN_W-1:0] byte_len,
    input  logic [WD_W-1:0]  wd_limit,
    input  logic             start_full,
    input  logic             start_pr,
    input  logic             clear,
    input  logic             conf_done,
    input  logic             st_ready,
    input  logic [1:0]       pr_status,
    input  logic             wd_expired,
    output logic [LEN_W-1:0] pos_o,
    output logic [LEN_W-1:0] len_o,
    output logic [2:0]       bytes_o,
    output logic [WD_W-1:0]  limit_o,
    output logic             wd_run,
    output logic             st_valid,
    output logic             freeze,
    output logic             pr_request,
    output logic             done,
    output logic             error,
    output logic [1:0]       err_cause
);
    host_state_t      state, state_nxt;
    err_cause_t       cause_q, cause_nxt;
    logic             is_pr;
    logic [2:0]       bytes_q;
    logic [LEN_W-1:0] len_q;
    logic [LEN_W-1:0] pos_q;
    logic [WD_W-1:0]  limit_q;
    logic             accept;
    logic             status_bad;
    logic             last_beat;
    logic             finished;
    logic [LEN_W:0]   pos_sum;

    assign accept     = (state == ST_IDLE || state == ST_DONE) && (start_pr || start_full);
    assign status_bad = !pr_status[1];
    assign pos_sum    = {1'b0, pos_q} + (LEN_W+1)'(bytes_q);
    assign last_beat  = pos_sum >= {1'b0, len_q};
    assign finished   = is_pr ? (pr_status == 2'd3) : (conf_done && !st_ready);

    // Next-state and error-cause decision.
    always_comb begin
        state_nxt = state;
        cause_nxt = cause_q;
        case (state)
            ST_IDLE, ST_DONE: begin
                if (start_pr) begin
                    state_nxt = ST_FREEZE;
                    cause_nxt = CAUSE_NONE;
                end else if (start_full) begin
                    cause_nxt = CAUSE_NONE;
                    if (!conf_done && st_ready) begin
                        state_nxt = (byte_len == '0) ? ST_WAIT : ST_STREAM;
                    end else begin
                        state_nxt = ST_ERROR;
                        cause_nxt = CAUSE_PINS;
                    end
                end else if (clear && state == ST_DONE) begin
                    state_nxt = ST_IDLE;
                end
            end
            ST_FREEZE: state_nxt = ST_REQ;
            ST_REQ: begin
                if (st_ready) begin
                    state_nxt = (len_q == '0) ? ST_WAIT : ST_STREAM;
                end
            end
            ST_STREAM: begin
                if (is_pr && status_bad) begin
                    state_nxt = ST_ERROR;
                    cause_nxt = CAUSE_STATUS;
                end else if (st_ready && last_beat) begin
                    state_nxt = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (finished) begin
                    state_nxt = ST_DONE;
                end else if (is_pr && status_bad) begin
                    state_nxt = ST_ERROR;
                    cause_nxt = CAUSE_STATUS;
                end else if (wd_expired) begin
                    state_nxt = ST_ERROR;
                    cause_nxt = CAUSE_TIMEOUT;
                end
            end
            ST_ERROR: begin
                if (clear) begin
                    state_nxt = ST_IDLE;
                    cause_nxt = CAUSE_NONE;
                end
            end
            default: state_nxt = ST_IDLE;
        endcase
    end

    // State and cause registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            cause_q <= CAUSE_NONE;
        end else begin
            state   <= state_nxt;
            cause_q <= cause_nxt;
        end
    end

    // Operation settings captured at an accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            is_pr   <= 1'b0;
            bytes_q <= 3'd1;
            len_q   <= '0;
            limit_q <= '0;
        end else if (accept) begin
            is_pr   <= start_pr;
            bytes_q <= beat_bytes(mode_sel);
            len_q   <= byte_len;
            limit_q <= wd_limit;
        end
    end

    // Byte offset of the current beat: cleared at start, advanced per transfer.
    always_ff @(posedge clk) begin
        if (!rst_n || accept) begin
            pos_q <= '0;
        end else if (state == ST_STREAM && st_ready && !(is_pr && status_bad)) begin
            pos_q <= pos_sum[LEN_W-1:0];
        end
    end

    assign pos_o      = pos_q;
    assign len_o      = len_q;
    assign bytes_o    = bytes_q;
    assign limit_o    = limit_q;
    assign wd_run     = (state == ST_WAIT);
    assign st_valid   = (state == ST_STREAM);
    assign freeze     = is_pr && (state inside {ST_FREEZE, ST_REQ, ST_STREAM, ST_WAIT, ST_ERROR});
    assign pr_request = is_pr && (state inside {ST_REQ, ST_STREAM, ST_WAIT});
    assign done       = (state == ST_DONE);
    assign error      = (state == ST_ERROR);
    assign err_cause  = cause_q;

    a_r4_freeze_leads_request: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pr_request) |-> $past(freeze));

    a_r5_valid_after_ready: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_valid) |-> $past(st_ready));

    a_r6_stall_holds_beat: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && !st_ready && !(is_pr && status_bad)) |=> (st_valid && $stable(pos_q)));

    a_r10_unfreeze_on_finish: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(freeze) |-> ($past(pr_status) == 2'd3 || $past(clear)));

    a_r12_error_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ERROR && !clear) |=> (state == ST_ERROR));

endmodule

// File: rtl/prhost_seq.sv
// Top level of the partial reconfiguration host sequencer: joins the control
// state machine, the byte-lane packer and the completion watchdog.
// Assumes a combinational-read word buffer and a target that follows the
// freeze, request, ready and status handshake.
module prhost_seq #(
    parameter int LEN_W = 16,
    parameter int WD_W  = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       mode_sel,
    input  logic [LEN_W-1:0] byte_len,
    input  logic [WD_W-1:0]  wd_limit,
    input  logic             start_full,
    input  logic             start_pr,
    input  logic             clear,
    input  logic             conf_done,
    input  logic             st_ready,
    input  logic [1:0]       pr_status,
    output logic [LEN_W-3:0] buf_addr,
    input  logic [31:0]      buf_rdata,
    output logic             st_valid,
    output logic [31:0]      st_data,
    output logic             freeze,
    output logic             pr_request,
    output logic             done,
    output logic             error,
    output logic [1:0]       err_cause
);
    logic [LEN_W-1:0] pos;
    logic [LEN_W-1:0] len_q;
    logic [2:0]       bytes_q;
    logic [WD_W-1:0]  limit_q;
    logic             wd_run;
    logic             wd_expired;

    prhost_ctrl #(.LEN_W(LEN_W), .WD_W(WD_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_sel   (mode_sel),
        .byte_len   (byte_len),
        .wd_limit   (wd_limit),
        .start_full (start_full),
        .start_pr   (start_pr),
        .clear      (clear),
        .conf_done  (conf_done),
        .st_ready   (st_ready),
        .pr_status  (pr_status),
        .wd_expired (wd_expired),
        .pos_o      (pos),
        .len_o      (len_q),
        .bytes_o    (bytes_q),
        .limit_o    (limit_q),
        .wd_run     (wd_run),
        .st_valid   (st_valid),
        .freeze     (freeze),
        .pr_request (pr_request),
        .done       (done),
        .error      (error),
        .err_cause  (err_cause)
    );

    prhost_packer #(.LEN_W(LEN_W)) u_pack (
        .bytes (bytes_q),
        .pos   (pos),
        .len   (len_q),
        .word  (buf_rdata),
        .addr  (buf_addr),
        .data  (st_data)
    );

    prhost_wdog #(.WD_W(WD_W)) u_wdog (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (wd_run),
        .limit   (limit_q),
        .expired (wd_expired)
    );

endmodule

// File: tb/prhost_seq_test.sv
// Self-checking bench: a behavioural model of the host runs beside the
// design and every output is compared on each clock.
module prhost_seq_test;
    localparam int CLK_PERIOD = 10;
    localparam int LEN_W = 16;
    localparam int WD_W  = 12;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [1:0]       mode_sel = '0;
    logic [LEN_W-1:0] byte_len = '0;
    logic [WD_W-1:0]  wd_limit = 12'd30;
    logic             start_full = 1'b0, start_pr = 1'b0, clear = 1'b0;
    logic             conf_done = 1'b0, st_ready = 1'b1;
    logic [1:0]       pr_status = 2'd2;
    logic [LEN_W-3:0] buf_addr;
    logic [31:0]      buf_rdata;
    logic             st_valid, freeze, pr_request, done, error;
    logic [31:0]      st_data;
    logic [1:0]       err_cause;

    int    n_checks = 0;
    int    n_fail   = 0;
    int    cycles   = 0;
    int    beats    = 0;
    string tag      = "R1";
    logic [7:0] bmem [256];

    prhost_seq #(.LEN_W(LEN_W), .WD_W(WD_W)) uut (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .byte_len(byte_len),
        .wd_limit(wd_limit), .start_full(start_full), .start_pr(start_pr),
        .clear(clear), .conf_done(conf_done), .st_ready(st_ready),
        .pr_status(pr_status), .buf_addr(buf_addr), .buf_rdata(buf_rdata),
        .st_valid(st_valid), .st_data(st_data), .freeze(freeze),
        .pr_request(pr_request), .done(done), .error(error), .err_cause(err_cause)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Buffer: word w holds bytes 4w..4w+3, lowest byte in bits 7:0.
    always_comb begin
        int w;
        w = int'(buf_addr[5:0]);
        buf_rdata = {bmem[4*w+3], bmem[4*w+2], bmem[4*w+1], bmem[4*w]};
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
        end
    endtask

    // ---------------- behavioural model ----------------
    typedef enum int {M_IDLE, M_FRZ, M_REQ, M_STR, M_WAIT, M_DONE, M_ERR} mstate_t;
    mstate_t m_st = M_IDLE;
    bit m_pr = 0;
    int m_b = 1, m_len = 0, m_pos = 0, m_wd = 0, m_lim = 0, m_cause = 0;

    function automatic int width_of(input logic [1:0] c);
        return (c == 2'd1) ? 2 : (c == 2'd2) ? 4 : 1;
    endfunction

    always @(posedge clk) begin
        if (st_valid && st_ready) beats++;
        if (!rst_n) begin
            m_st = M_IDLE; m_pr = 0; m_cause = 0; m_pos = 0; m_wd = 0;
        end else begin
            case (m_st)
                M_IDLE, M_DONE: begin
                    if (start_pr || start_full) begin
                        m_pr = start_pr; m_b = width_of(mode_sel); m_len = int'(byte_len);
                        m_lim = int'(wd_limit); m_pos = 0; m_cause = 0; m_wd = 0;
                        if (start_pr) m_st = M_FRZ;
                        else if (conf_done == 0 && st_ready == 1) m_st = (m_len == 0) ? M_WAIT : M_STR;
                        else begin m_st = M_ERR; m_cause = 1; end
                    end else if (clear && m_st == M_DONE) m_st = M_IDLE;
                end
                M_FRZ: m_st = M_REQ;
                M_REQ: if (st_ready) m_st = (m_len == 0) ? M_WAIT : M_STR;
                M_STR: begin
                    if (m_pr && pr_status < 2) begin m_st = M_ERR; m_cause = 2; end
                    else if (st_ready) begin
                        m_pos += m_b;
                        if (m_pos >= m_len) begin m_st = M_WAIT; m_wd = 0; end
                    end
                end
                M_WAIT: begin
                    if (m_pr ? (pr_status == 3) : (conf_done && !st_ready)) m_st = M_DONE;
                    else if (m_pr && pr_status < 2) begin m_st = M_ERR; m_cause = 2; end
                    else if (m_wd == m_lim) begin m_st = M_ERR; m_cause = 3; end
                    else m_wd++;
                end
                M_ERR: if (clear) begin m_st = M_IDLE; m_cause = 0; end
                default: m_st = M_IDLE;
            endcase
        end
    end

    function automatic logic [31:0] exp_data();
        logic [31:0] d = '0;
        for (int i = 0; i < 4; i++)
            if (i < m_b && m_pos + i < m_len) d[8*i +: 8] = bmem[(m_pos + i) & 255];
        return d;
    endfunction

    // Cycle compare, away from the active edge.
    always @(negedge clk) begin
        #1;
        if (rst_n) begin
            bit ev, ef, er;
            ev = (m_st == M_STR);
            ef = m_pr && (m_st inside {M_FRZ, M_REQ, M_STR, M_WAIT, M_ERR});
            er = m_pr && (m_st inside {M_REQ, M_STR, M_WAIT});
            chk(st_valid == ev, tag, "st_valid", st_valid, ev);
            chk(freeze == ef, tag, "freeze", freeze, ef);
            chk(pr_request == er, tag, "pr_request", pr_request, er);
            chk(done == (m_st == M_DONE), tag, "done", done, m_st == M_DONE);
            chk(error == (m_st == M_ERR), tag, "error", error, m_st == M_ERR);
            chk(err_cause == 2'(m_cause), tag, "err_cause", err_cause, m_cause);
            if (ev) begin
                chk(buf_addr == (LEN_W-2)'(m_pos / 4), tag, "buf_addr", buf_addr, m_pos / 4);
                chk(st_data == exp_data(), tag, "st_data", st_data, exp_data());
            end
        end
    end

    // ---------------- stimulus ----------------
    task automatic fill(input int seed);
        for (int i = 0; i < 256; i++) bmem[i] = 8'((i * 37 + seed * 11 + 5) ^ (i >> 3));
    endtask

    task automatic run(input int n, input int pat);
        for (int c = 0; c < n; c++) begin
            @(negedge clk);
            st_ready = (pat == 0) ? 1'b1 : (pat == 1) ? ((c % 3) != 2) : 1'b0;
        end
    endtask

    task automatic pulse(input int which);
        @(negedge clk);
        if (which == 0) start_full = 1'b1;
        else if (which == 1) start_pr = 1'b1;
        else clear = 1'b1;
        @(negedge clk);
        start_full = 1'b0; start_pr = 1'b0; clear = 1'b0;
    endtask

    initial begin
        fill(1);
        repeat (3) @(negedge clk);
        #1;
        chk(st_valid == 0 && freeze == 0 && pr_request == 0 && done == 0 && error == 0,
            "R1", "outputs in reset", {st_valid, freeze, pr_request, done, error}, 0);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(err_cause == 0 && error == 0 && freeze == 0, "R1", "idle after reset",
            {err_cause, error, freeze}, 0);

        // Full load, 8-bit, odd length.
        tag = "R2"; mode_sel = 2'd0; byte_len = 5; wd_limit = 30; beats = 0;
        pulse(0); #1;
        chk(st_valid == 1, "R2", "stream starts after start", st_valid, 1);
        run(8, 0);
        tag = "R3";
        run(3, 0);
        chk(done == 0, "R3", "no done while pins unchanged", done, 0);
        conf_done = 1'b1; st_ready = 1'b0;
        run(2, 2); #1;
        chk(done == 1, "R3", "done after pin check", done, 1);
        chk(beats == 5, "R8", "beats 8-bit len 5", beats, 5);

        // Pin pre-check fails; starts ignored in error.
        tag = "R2";
        conf_done = 1'b1; st_ready = 1'b1;
        pulse(0); run(1, 0); #1;
        chk(error == 1 && err_cause == 1, "R2", "pin precheck error", {error, err_cause}, 3'b101);
        tag = "R12";
        conf_done = 1'b0;
        pulse(1); run(3, 0); #1;
        chk(error == 1 && freeze == 0, "R12", "start ignored in error", {error, freeze}, 2'b10);
        pulse(2); #1;
        chk(error == 0, "R12", "clear leaves error", error, 0);

        // Partial reconfiguration, 16-bit, odd length, ready stalls.
        fill(2); tag = "R4"; pr_status = 2'd2; st_ready = 1'b0;
        mode_sel = 2'd1; byte_len = 7; wd_limit = 40; beats = 0;
        @(negedge clk); start_pr = 1'b1;
        @(negedge clk); start_pr = 1'b0; #1;
        chk(freeze == 1 && pr_request == 0, "R4", "freeze alone", {freeze, pr_request}, 2'b10);
        @(negedge clk); #1;
        chk(freeze == 1 && pr_request == 1, "R4", "freeze then request", {freeze, pr_request}, 2'b11);
        tag = "R5";
        run(4, 2); #1;
        chk(st_valid == 0, "R5", "no data before ready", st_valid, 0);
        tag = "R13"; mode_sel = 2'd2; byte_len = 3; wd_limit = 1;
        run(14, 1);
        run(3, 0);
        tag = "R10"; pr_status = 2'd3;
        run(2, 0); #1;
        chk(done == 1 && freeze == 0 && pr_request == 0, "R10", "completion unfreezes",
            {done, freeze, pr_request}, 3'b100);
        chk(beats == 4, "R8", "beats 16-bit len 7", beats, 4);
        pr_status = 2'd2;

        // Watchdog timeout, 32-bit.
        fill(3); tag = "R11"; mode_sel = 2'd2; byte_len = 10; wd_limit = 4;
        pulse(1); run(16, 0); #1;
        chk(error == 1 && err_cause == 3 && freeze == 1, "R11", "timeout error",
            {error, err_cause, freeze}, 4'b1111);
        tag = "R12"; pulse(2); #1;
        chk(freeze == 0 && error == 0, "R12", "clear releases freeze", {freeze, error}, 0);

        // Status error mid-stream.
        fill(4); tag = "R9"; mode_sel = 2'd2; byte_len = 40; wd_limit = 30;
        pulse(1); run(4, 0);
        pr_status = 2'd1;
        run(2, 0); #1;
        chk(error == 1 && err_cause == 2 && st_valid == 0 && pr_request == 0 && freeze == 1,
            "R9", "status abort", {error, err_cause, st_valid, pr_request, freeze}, 6'b110001);
        pr_status = 2'd2; pulse(2);

        // Zero length with unused width code.
        tag = "R8"; mode_sel = 2'd3; byte_len = 0; beats = 0;
        pulse(1); run(5, 0);
        pr_status = 2'd3; run(2, 0); #1;
        chk(done == 1 && beats == 0, "R8", "zero length no beats", {done, beats}, 1);
        pr_status = 2'd2;

        // Full load, 16-bit and 32-bit, ready stalls.
        fill(5); tag = "R6"; conf_done = 1'b0; st_ready = 1'b1;
        mode_sel = 2'd1; byte_len = 9; wd_limit = 60; beats = 0;
        pulse(0); run(20, 1);
        conf_done = 1'b1; st_ready = 1'b0; run(2, 2); #1;
        chk(done == 1 && beats == 5, "R6", "16-bit stalled load", {done, 8'(beats)}, 9'h105);
        fill(6); tag = "R7"; conf_done = 1'b0; st_ready = 1'b1;
        mode_sel = 2'd2; byte_len = 13; beats = 0;
        pulse(0); run(12, 1);
        conf_done = 1'b1; st_ready = 1'b0; run(2, 2); #1;
        chk(done == 1 && beats == 4, "R7", "32-bit load", {done, 8'(beats)}, 9'h104);

        run(3, 2);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    // Watchdog for a hung run.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected under 20000", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule